// File: doc/BRIEF.md
# Instruction Cache Line-State Coherency Guard

This block holds the per-line bookkeeping of a small instruction cache (tag, valid bit, lock bit and a small mask field per line) and keeps it coherent with flash memory while the flash is being written. When a program or erase sequence begins, the block stalls every cache lookup, so that no instruction is served from the cache while the flash contents are changing. When the sequence ends, the block applies an invalidation policy and then releases the stall.

A single mode input selects the policy. In full mode, every line is invalidated and unlocked, and every mask is cleared. In selective mode, only unlocked lines are invalidated, and locked lines survive unchanged. Software may also write a line's tag, valid bit, lock bit and mask directly. A line made valid this way hits on a matching lookup even though its data was never filled. A tag write that arrives during a stall is held back and applied once the stall is released. The block has no interrupt output. The flash programming engine and the data arrays lie outside it.

Top module: `lcs_guard`

## Requirements
- R1: A `prog_start` pulse while idle drives `lk_stall` high from the next cycle. It stays high until released per R3.
- R2: While `lk_stall` is high, `lk_hit` is 0 whatever the lookup inputs are.
- R3: A `prog_done` pulse while programming causes the flush to take effect at the clock edge that ends the cycle after the pulse. `lk_stall` is first low one cycle after that, which is the second cycle after the pulse.
- R4: If `coh_full` is 1 during the flush cycle, every line becomes invalid and unlocked, and its mask becomes 0.
- R5: If `coh_full` is 0 during the flush cycle, unlocked lines become invalid. Locked lines keep their valid, lock and mask values. Tags are never changed by a flush.
- R6: A tag write (`tw_valid`=1) with the stall low loads line `tw_idx` with `tw_tag`, `tw_set_valid`, `tw_set_lock` and `tw_mask` at the next clock edge. A later matching lookup hits with no fill.
- R7: A tag write during a stall is held in one slot, and the latest write wins. It is applied at the first clock edge with the stall low, so lookups see it from the cycle after that edge. A new write in that same cycle is held and applied one cycle later.
- R8: `lk_hit`=1 when `lk_valid`=1, the stall is low, and some valid line's tag equals `lk_tag`. `lk_line` is the lowest such index, and `lk_lock` and `lk_mask` are that line's values. On a miss, all three are 0.
- R9: `prog_start` is ignored while stalled, and `prog_done` is ignored unless programming is in progress.
- R10: After reset, every line has a tag of 0, is invalid and unlocked, and has a mask of 0. The stall is low and no write is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_start | input | 1 | Flash program/erase sequence begins |
| prog_done | input | 1 | Flash program/erase sequence finished |
| coh_full | input | 1 | 1: full flush, 0: selective flush keeping locked lines |
| tw_valid | input | 1 | Tag write request |
| tw_idx | input | 2 | Line written |
| tw_tag | input | 28 | Tag value written |
| tw_set_valid | input | 1 | Valid bit written |
| tw_set_lock | input | 1 | Lock bit written |
| tw_mask | input | 4 | Mask value written |
| lk_valid | input | 1 | Lookup request |
| lk_tag | input | 28 | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_line | output | 2 | Index of the hitting line |
| lk_lock | output | 1 | Lock bit of the hitting line |
| lk_mask | output | 4 | Mask of the hitting line |
| lk_stall | output | 1 | Lookups stalled by flash programming |

## Verification
A table of tag writes, each followed by a lookup, exercises the hit logic with several patterns:
- an exact match,
- a line written invalid,
- a tag that differs only in its low bit,
- two lines holding the same tag, which exposes the lowest-index priority,
- a duplicate line that remains after the lower one is invalidated.

Programming sequences then run in selective mode and in full mode over a mix of locked and unlocked lines. Lookups that hit or miss after each flush tell the two policies apart. A tag write issued during the stall shows whether it is held and applied only after release. Stray `prog_done` and `prog_start` pulses, in idle and in the flush cycle, show whether the sequencer wrongly accepts them.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROG  = 2'd1,
    ST_APPLY = 2'd2
  } seq_e;

  // A line stays valid across a flush only if locked and the mode is selective.
  function automatic logic flushed_valid(input logic valid, input logic lock,
                                         input logic full);
    return valid & lock & ~full;
  endfunction

  // A full flush drops every lock; a selective one keeps them.
  function automatic logic flushed_lock(input logic lock, input logic full);
    return lock & ~full;
  endfunction
endpackage

// File: rtl/lcs_seq.sv
module lcs_seq
  import lcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prog_start,
  input  logic prog_done,
  output logic stall_o,
  output logic flush_o
);
  seq_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (prog_start) state_d = ST_PROG;
      ST_PROG:  if (prog_done)  state_d = ST_APPLY;
      ST_APPLY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign stall_o = (state_q != ST_IDLE);
  assign flush_o = (state_q == ST_APPLY);

  // R1
  start_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && prog_start) |=> stall_o);
  // R3
  done_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROG && prog_done) |=> flush_o);
  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_o |=> !stall_o);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_o && !prog_start) |=> !stall_o);
endmodule

// File: rtl/lcs_twq.sv
module lcs_twq #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 28,
  parameter int MASK_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              tw_valid_i,
  input  logic [IDX_W-1:0]  tw_idx_i,
  input  logic [TAG_W-1:0]  tw_tag_i,
  input  logic              tw_v_i,
  input  logic              tw_l_i,
  input  logic [MASK_W-1:0] tw_m_i,
  output logic              pend_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              wr_v_o,
  output logic              wr_l_o,
  output logic [MASK_W-1:0] wr_m_o
);
  logic              pend_q;
  logic [IDX_W-1:0]  p_idx_q;
  logic [TAG_W-1:0]  p_tag_q;
  logic              p_v_q, p_l_q;
  logic [MASK_W-1:0] p_m_q;
  logic              capture;

  // A new write is parked when stalled, or when the slot is being drained now.
  assign capture = tw_valid_i && (stall_i || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      p_idx_q <= '0;
      p_tag_q <= '0;
      p_v_q   <= 1'b0;
      p_l_q   <= 1'b0;
      p_m_q   <= '0;
    end else begin
      if (capture) begin
        pend_q  <= 1'b1;
        p_idx_q <= tw_idx_i;
        p_tag_q <= tw_tag_i;
        p_v_q   <= tw_v_i;
        p_l_q   <= tw_l_i;
        p_m_q   <= tw_m_i;
      end else if (!stall_i) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign pend_o   = pend_q;
  assign wr_en_o  = !stall_i && (pend_q || tw_valid_i);
  assign wr_idx_o = pend_q ? p_idx_q : tw_idx_i;
  assign wr_tag_o = pend_q ? p_tag_q : tw_tag_i;
  assign wr_v_o   = pend_q ? p_v_q   : tw_v_i;
  assign wr_l_o   = pend_q ? p_l_q   : tw_l_i;
  assign wr_m_o   = pend_q ? p_m_q   : tw_m_i;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && tw_valid_i) |=> pend_q);
  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !stall_i && !tw_valid_i) |=> !pend_q);
endmodule

// File: rtl/lcs_array.sv
module lcs_array
  import lcs_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 28,
  parameter int MASK_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flush_i,
  input  logic                               full_i,
  input  logic                               wr_en_i,
  input  logic [IDX_W-1:0]                   wr_idx_i,
  input  logic [TAG_W-1:0]                   wr_tag_i,
  input  logic                               wr_v_i,
  input  logic                               wr_l_i,
  input  logic [MASK_W-1:0]                  wr_m_i,
  output logic [NUM_LINES-1:0]               valid_o,
  output logic [NUM_LINES-1:0]               lock_o,
  output logic [NUM_LINES-1:0][TAG_W-1:0]    tag_o,
  output logic [NUM_LINES-1:0][MASK_W-1:0]   mask_o
);
  logic [NUM_LINES-1:0]             valid_q, lock_q;
  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_q;
  logic [NUM_LINES-1:0][MASK_W-1:0] mask_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        lock_q[g]  <= 1'b0;
        tag_q[g]   <= '0;
        mask_q[g]  <= '0;
      end else if (flush_i) begin
        valid_q[g] <= flushed_valid(valid_q[g], lock_q[g], full_i);
        lock_q[g]  <= flushed_lock(lock_q[g], full_i);
        if (full_i) mask_q[g] <= '0;
      end else if (sel) begin
        valid_q[g] <= wr_v_i;
        lock_q[g]  <= wr_l_i;
        tag_q[g]   <= wr_tag_i;
        mask_q[g]  <= wr_m_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign lock_o  = lock_q;
  assign tag_o   = tag_q;
  assign mask_o  = mask_q;

  // R4
  full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && full_i) |=> (valid_q == '0 && lock_q == '0 && mask_q == '0));
  // R5
  sel_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !full_i) |=> (valid_q == $past(valid_q & lock_q) &&
                              lock_q == $past(lock_q) && tag_q == $past(tag_q)));
endmodule

// File: rtl/lcs_lookup.sv
module lcs_lookup #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 28,
  parameter int MASK_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             stall_i,
  input  logic                             lk_valid_i,
  input  logic [TAG_W-1:0]                 lk_tag_i,
  input  logic [NUM_LINES-1:0]             valid_i,
  input  logic [NUM_LINES-1:0]             lock_i,
  input  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_i,
  input  logic [NUM_LINES-1:0][MASK_W-1:0] mask_i,
  output logic                             hit_o,
  output logic [IDX_W-1:0]                 line_o,
  output logic                             lock_o,
  output logic [MASK_W-1:0]                mask_o
);
  function automatic logic line_matches(input logic v, input logic [TAG_W-1:0] a,
                                        input logic [TAG_W-1:0] b);
    return v && (a == b);
  endfunction

  logic             any_q;
  logic [IDX_W-1:0] idx;

  // Scan from the top so the lowest matching index wins.
  always_comb begin
    any_q = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (line_matches(valid_i[i], tag_i[i], lk_tag_i)) begin
        any_q = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  assign hit_o  = lk_valid_i && !stall_i && any_q;
  assign line_o = hit_o ? idx : '0;
  assign lock_o = hit_o ? lock_i[idx] : 1'b0;
  assign mask_o = hit_o ? mask_i[idx] : '0;

  // R2
  stall_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !hit_o);
  // R8
  hit_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (lk_valid_i && valid_i[line_o] && tag_i[line_o] == lk_tag_i));
endmodule

// File: rtl/lcs_guard.sv
module lcs_guard #(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 28,
  parameter int MASK_W    = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic              prog_done,
  input  logic              coh_full,
  input  logic              tw_valid,
  input  logic [IDX_W-1:0]  tw_idx,
  input  logic [TAG_W-1:0]  tw_tag,
  input  logic              tw_set_valid,
  input  logic              tw_set_lock,
  input  logic [MASK_W-1:0] tw_mask,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_line,
  output logic              lk_lock,
  output logic [MASK_W-1:0] lk_mask,
  output logic              lk_stall
);
  logic                             stall_w, flush_w, pend_w;
  logic                             wr_en_w, wr_v_w, wr_l_w;
  logic [IDX_W-1:0]                 wr_idx_w;
  logic [TAG_W-1:0]                 wr_tag_w;
  logic [MASK_W-1:0]                wr_m_w;
  logic [NUM_LINES-1:0]             valid_w, lock_w;
  logic [NUM_LINES-1:0][TAG_W-1:0]  tag_w;
  logic [NUM_LINES-1:0][MASK_W-1:0] mask_w;

  lcs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_done(prog_done),
    .stall_o(stall_w), .flush_o(flush_w)
  );

  lcs_twq #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_twq (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_w),
    .tw_valid_i(tw_valid), .tw_idx_i(tw_idx), .tw_tag_i(tw_tag),
    .tw_v_i(tw_set_valid), .tw_l_i(tw_set_lock), .tw_m_i(tw_mask),
    .pend_o(pend_w), .wr_en_o(wr_en_w), .wr_idx_o(wr_idx_w), .wr_tag_o(wr_tag_w),
    .wr_v_o(wr_v_w), .wr_l_o(wr_l_w), .wr_m_o(wr_m_w)
  );

  lcs_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_array (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_w), .full_i(coh_full),
    .wr_en_i(wr_en_w), .wr_idx_i(wr_idx_w), .wr_tag_i(wr_tag_w),
    .wr_v_i(wr_v_w), .wr_l_i(wr_l_w), .wr_m_i(wr_m_w),
    .valid_o(valid_w), .lock_o(lock_w), .tag_o(tag_w), .mask_o(mask_w)
  );

  lcs_lookup #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .MASK_W(MASK_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_w),
    .lk_valid_i(lk_valid), .lk_tag_i(lk_tag),
    .valid_i(valid_w), .lock_i(lock_w), .tag_i(tag_w), .mask_i(mask_w),
    .hit_o(lk_hit), .line_o(lk_line), .lock_o(lk_lock), .mask_o(lk_mask)
  );

  assign lk_stall = stall_w;

  // R6
  no_write_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_w |-> !stall_w);
  // R7
  flush_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_w |-> !wr_en_w);
  // R10
  held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_w && !$past(stall_w) && !tw_valid && !pend_w) |=> !pend_w);
endmodule

// File: tb/lcs_guard_bench.sv
module lcs_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_start = 0, prog_done = 0, coh_full = 0;
  logic        tw_valid = 0, tw_set_valid = 0, tw_set_lock = 0;
  logic [1:0]  tw_idx = '0;
  logic [27:0] tw_tag = '0;
  logic [3:0]  tw_mask = '0;
  logic        lk_valid = 0;
  logic [27:0] lk_tag = '0;
  logic        lk_hit, lk_lock, lk_stall;
  logic [1:0]  lk_line;
  logic [3:0]  lk_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lcs_guard u_lcs_guard (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_done(prog_done),
    .coh_full(coh_full), .tw_valid(tw_valid), .tw_idx(tw_idx), .tw_tag(tw_tag),
    .tw_set_valid(tw_set_valid), .tw_set_lock(tw_set_lock), .tw_mask(tw_mask),
    .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_line(lk_line),
    .lk_lock(lk_lock), .lk_mask(lk_mask), .lk_stall(lk_stall)
  );

  typedef struct packed {
    logic [1:0]  idx;
    logic [27:0] wtag;
    logic        v;
    logic        l;
    logic [3:0]  m;
    logic [27:0] ltag;
    logic        hit;
    logic [1:0]  line;
    logic        lk;
    logic [3:0]  mk;
  } vec_t;

  // Each row: tag write, then a lookup with its expected outcome (R6, R8).
  localparam vec_t VECS [8] = '{
    '{2'd0, 28'h0001000, 1'b1, 1'b0, 4'h3, 28'h0001000, 1'b1, 2'd0, 1'b0, 4'h3},
    '{2'd1, 28'h0002000, 1'b1, 1'b1, 4'h5, 28'h0002000, 1'b1, 2'd1, 1'b1, 4'h5},
    '{2'd2, 28'h0003000, 1'b0, 1'b0, 4'h0, 28'h0003000, 1'b0, 2'd0, 1'b0, 4'h0},
    '{2'd3, 28'hABCDEF1, 1'b1, 1'b1, 4'hA, 28'hABCDEF0, 1'b0, 2'd0, 1'b0, 4'h0},
    '{2'd2, 28'h0001000, 1'b1, 1'b0, 4'h7, 28'h0001000, 1'b1, 2'd0, 1'b0, 4'h3},
    '{2'd0, 28'h0001000, 1'b0, 1'b0, 4'h0, 28'h0001000, 1'b1, 2'd2, 1'b0, 4'h7},
    '{2'd2, 28'h0004000, 1'b1, 1'b0, 4'h1, 28'hABCDEF1, 1'b1, 2'd3, 1'b1, 4'hA},
    '{2'd0, 28'h0005000, 1'b1, 1'b0, 4'h2, 28'h0005000, 1'b1, 2'd0, 1'b0, 4'h2}
  };

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  // Called just after a falling edge; the write lands at the next rising edge.
  task automatic tag_write(input logic [1:0] idx, input logic [27:0] tag,
                           input logic v, input logic l, input logic [3:0] m);
    tw_valid = 1; tw_idx = idx; tw_tag = tag; tw_set_valid = v; tw_set_lock = l; tw_mask = m;
    @(negedge clk);
    tw_valid = 0;
  endtask

  task automatic look(input string req, input logic [27:0] tag, input logic eh,
                      input logic [1:0] el, input logic elk, input logic [3:0] em);
    lk_valid = 1; lk_tag = tag;
    #1;
    check({req, " hit"},  32'(lk_hit),  32'(eh));
    check({req, " line"}, 32'(lk_line), 32'(el));
    check({req, " lock"}, 32'(lk_lock), 32'(elk));
    check({req, " mask"}, 32'(lk_mask), 32'(em));
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 stall after reset", 32'(lk_stall), 32'd0);
    look("R10 empty lines", 28'h0000000, 1'b0, 2'd0, 1'b0, 4'h0);

    // R6 / R8 table walk
    foreach (VECS[k]) begin
      tag_write(VECS[k].idx, VECS[k].wtag, VECS[k].v, VECS[k].l, VECS[k].m);
      look($sformatf("R8 vector %0d", k), VECS[k].ltag, VECS[k].hit, VECS[k].line,
           VECS[k].lk, VECS[k].mk);
    end
    // Lines now: 0:5000 v l0 m2, 1:2000 v l1 m5, 2:4000 v l0 m1, 3:ABCDEF1 v l1 mA

    // Selective flush (R1, R2, R3, R5, R7)
    coh_full = 0;
    prog_start = 1;
    @(negedge clk);
    prog_start = 0;
    check("R1 stall after start", 32'(lk_stall), 32'd1);
    look("R2 lookup while stalled", 28'h0002000, 1'b0, 2'd0, 1'b0, 4'h0);
    tag_write(2'd0, 28'h0006000, 1'b1, 1'b1, 4'h9);
    look("R7 held write not visible", 28'h0006000, 1'b0, 2'd0, 1'b0, 4'h0);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    check("R3 stall in flush cycle", 32'(lk_stall), 32'd1);
    @(negedge clk);
    check("R3 stall released", 32'(lk_stall), 32'd0);
    look("R5 locked line kept", 28'h0002000, 1'b1, 2'd1, 1'b1, 4'h5);
    look("R5 unlocked line 0 dropped", 28'h0005000, 1'b0, 2'd0, 1'b0, 4'h0);
    look("R5 unlocked line 2 dropped", 28'h0004000, 1'b0, 2'd0, 1'b0, 4'h0);
    look("R5 locked line 3 kept", 28'hABCDEF1, 1'b1, 2'd3, 1'b1, 4'hA);
    look("R7 held write pending at release", 28'h0006000, 1'b0, 2'd0, 1'b0, 4'h0);
    @(negedge clk);
    look("R7 held write applied", 28'h0006000, 1'b1, 2'd0, 1'b1, 4'h9);

    // Full flush (R4)
    coh_full = 1;
    prog_start = 1;
    @(negedge clk);
    prog_start = 0;
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    @(negedge clk);
    check("R4 stall released", 32'(lk_stall), 32'd0);
    look("R4 locked line 0 dropped", 28'h0006000, 1'b0, 2'd0, 1'b0, 4'h0);
    look("R4 locked line 1 dropped", 28'h0002000, 1'b0, 2'd0, 1'b0, 4'h0);
    look("R4 locked line 3 dropped", 28'hABCDEF1, 1'b0, 2'd0, 1'b0, 4'h0);

    // Stray control pulses (R9)
    coh_full = 0;
    tag_write(2'd0, 28'h0007000, 1'b1, 1'b0, 4'h2);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    check("R9 done in idle ignored", 32'(lk_stall), 32'd0);
    @(negedge clk);
    check("R9 done in idle still idle", 32'(lk_stall), 32'd0);
    look("R9 line untouched", 28'h0007000, 1'b1, 2'd0, 1'b0, 4'h2);
    prog_start = 1;
    @(negedge clk);
    prog_done = 1;
    @(negedge clk);
    prog_done = 0;
    check("R9 stall in flush cycle", 32'(lk_stall), 32'd1);
    @(negedge clk);
    prog_start = 0;
    check("R9 start during flush ignored", 32'(lk_stall), 32'd0);
    look("R5 unlocked line dropped", 28'h0007000, 1'b0, 2'd0, 1'b0, 4'h0);

    lk_valid = 0;
    @(negedge clk);
    summary();
  end
endmodule